// File: doc/BRIEF.md
# Stride Prefetch Prediction Table

The block observes a stream of load accesses, one per cycle, each tagged with the program counter of the load and the data address it touched. It keeps a direct-mapped table indexed by program counter. Each entry holds a partial-PC tag, the previous data address of that load, the last stride seen and a two-bit confidence state. When a load keeps advancing by the same distance, its entry settles into a steady state. From then on each access produces a prefetch address one stride ahead.

Each access reads its entry combinationally and compares the new delta with the stored stride. The entry is rewritten at the same clock edge. The prefetch request is registered, so a valid pulse and its address appear in the cycle after the access. Cache fill, bus arbitration and request queuing belong to the surrounding logic.

Top module: `stride_pf_top`

## Requirements
- R1: After reset `pf_valid_o` is low and every table entry is empty, so the first access from any program counter produces no prefetch.
- R2: The entry index is `acc_pc_i[7:2]` and the tag is `acc_pc_i[15:8]` (defaults: 64 entries, 8-bit tag). An access whose index selects an empty entry or an entry with a different tag is a miss. A miss allocates the entry with state INITIAL, stride zero and the access address as the last address. A miss never issues a prefetch.
- R3: On a hit, delta = address minus stored last address, modulo 2^ADDR_W. The last-address field is rewritten with the current address on every hit, whatever the state.
- R4: On a hit, a delta equal to the stored stride (a match) moves the state as follows: INITIAL to STEADY, TRANSIENT to STEADY, STEADY stays STEADY, NO_PREDICTION to TRANSIENT. The stride is left unchanged.
- R5: On a hit, a mismatch moves the state as follows: INITIAL to TRANSIENT, TRANSIENT to NO_PREDICTION, STEADY to INITIAL, NO_PREDICTION stays NO_PREDICTION. The stride is replaced by the delta.
- R6: A prefetch is issued only when the updated state is STEADY and the stride is nonzero. One cycle after the access, `pf_valid_o` is high for one cycle and `pf_addr_o` = access address + stride, modulo 2^ADDR_W. A constant stride first prefetches on the third access.
- R7: A load whose address does not change reaches STEADY with zero stride and never issues a prefetch.
- R8: Two program counters with the same index and different tags replace each other's entry. After a replacement, the replaced program counter's next access is a miss.
- R9: Entries at different indices evolve independently when their accesses interleave cycle by cycle. This includes negative strides and strides that wrap past the top of the address space.
- R10: A cycle with `acc_valid_i` low changes no entry, and one cycle later `pf_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_pc_i | input | 32 | Program counter of the load |
| acc_addr_i | input | 32 | Data address of the load |
| pf_valid_o | output | 1 | Prefetch request, one cycle after the access |
| pf_addr_o | output | 32 | Prefetch address |

## Verification
The bench tries several address patterns, each chosen to separate states that would otherwise look alike:
- A positive constant stride shows when confidence is first reached.
- A repeated address shows that the zero-stride case is suppressed.
- A steady stream broken by one new distance shows that STEADY falls back to INITIAL, because the very next match prefetches again.
- A sequence of growing deltas drives an entry into NO_PREDICTION and shows that two matches are needed to leave it.

Aliased program counters check replacement. Interleaved negative-stride and wrapping streams show that the entries are independent and that the arithmetic is modular.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2,
    ST_NOPRED = 2'd3
  } pf_state_e;
endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 8,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              tag_hit_o,
  output logic [ADDR_W-1:0] last_o,
  output logic [ADDR_W-1:0] stride_o,
  output pf_state_e         state_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_last_i,
  input  logic [ADDR_W-1:0] wr_stride_i,
  input  pf_state_e         wr_state_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  last_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  pf_state_e          state_q  [ENTRIES];

  assign tag_hit_o = valid_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign last_o    = last_q[idx_i];
  assign stride_o  = stride_q[idx_i];
  assign state_o   = state_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[idx_i] <= 1'b1;
  end

  // payload needs no reset: gated by valid_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]    <= tag_i;
      last_q[idx_i]   <= wr_last_i;
      stride_q[idx_i] <= wr_stride_i;
      state_q[idx_i]  <= wr_state_i;
    end
  end

  // R10
  no_idle_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_q));
endmodule

// File: rtl/stride_pf_fsm.sv
module stride_pf_fsm
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hit_i,
  input  pf_state_e         cur_state_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [ADDR_W-1:0] addr_i,
  output pf_state_e         nxt_state_o,
  output logic [ADDR_W-1:0] nxt_stride_o,
  output logic              issue_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic [ADDR_W-1:0] delta;
  logic              match;

  assign delta = addr_i - last_i;
  assign match = (delta == stride_i);

  always_comb begin
    nxt_state_o  = ST_INIT;
    nxt_stride_o = '0;
    if (hit_i) begin
      nxt_stride_o = match ? stride_i : delta;
      unique case (cur_state_i)
        ST_INIT:   nxt_state_o = match ? ST_STEADY : ST_TRANS;
        ST_TRANS:  nxt_state_o = match ? ST_STEADY : ST_NOPRED;
        ST_STEADY: nxt_state_o = match ? ST_STEADY : ST_INIT;
        ST_NOPRED: nxt_state_o = match ? ST_TRANS  : ST_NOPRED;
        default:   nxt_state_o = ST_INIT;
      endcase
    end
  end

  assign issue_o   = valid_i && hit_i && (nxt_state_o == ST_STEADY) && (nxt_stride_o != '0);
  assign pf_addr_o = addr_i + nxt_stride_o;

  // R5
  steady_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_i && cur_state_i == ST_STEADY) |-> (nxt_state_o != ST_NOPRED));
  // R4
  nopred_slow_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_i && cur_state_i == ST_NOPRED) |-> (nxt_state_o != ST_STEADY));
  // R2
  miss_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hit_i) |-> !issue_o);
endmodule

// File: rtl/stride_pf_top.sv
module stride_pf_top
  import stride_pf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 8,
  parameter int PC_LSB  = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_LSB = PC_LSB + IDX_W,
  localparam int PC_TOP  = TAG_LSB + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [PC_W-1:0]   acc_pc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              tag_hit;
  logic [ADDR_W-1:0] ent_last, ent_stride, nxt_stride, pf_addr_d;
  pf_state_e         ent_state, nxt_state;
  logic              issue;
  logic              unused_pc;

  assign idx = acc_pc_i[PC_LSB +: IDX_W];
  assign tag = acc_pc_i[TAG_LSB +: TAG_W];
  assign unused_pc = ^{acc_pc_i[PC_W-1:PC_TOP], acc_pc_i[PC_LSB-1:0]};

  stride_pf_table #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .tag_i       (tag),
    .tag_hit_o   (tag_hit),
    .last_o      (ent_last),
    .stride_o    (ent_stride),
    .state_o     (ent_state),
    .wr_en_i     (acc_valid_i),
    .wr_last_i   (acc_addr_i),
    .wr_stride_i (nxt_stride),
    .wr_state_i  (nxt_state)
  );

  stride_pf_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (acc_valid_i),
    .hit_i        (tag_hit),
    .cur_state_i  (ent_state),
    .last_i       (ent_last),
    .stride_i     (ent_stride),
    .addr_i       (acc_addr_i),
    .nxt_state_o  (nxt_state),
    .nxt_stride_o (nxt_stride),
    .issue_o      (issue),
    .pf_addr_o    (pf_addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_o <= 1'b0;
      pf_addr_o  <= '0;
    end else begin
      pf_valid_o <= issue;
      if (issue) pf_addr_o <= pf_addr_d;
    end
  end

  // R10
  pf_needs_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> $past(acc_valid_i));
  // R7
  pf_nonzero_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (pf_addr_o != $past(acc_addr_i)));
endmodule

// File: tb/stride_pf_top_tb.sv
module stride_pf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stride_pf_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .acc_valid_i (acc_valid),
    .acc_pc_i    (acc_pc),
    .acc_addr_i  (acc_addr),
    .pf_valid_o  (pf_valid),
    .pf_addr_o   (pf_addr)
  );

  task automatic check(string req, logic ev, logic [31:0] ea);
    checks++;
    if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               req, pf_valid, pf_addr, ev, ea);
    end
  endtask

  // drive at negedge, result registered at posedge, sample next negedge
  task automatic acc(string req, logic [31:0] pc, logic [31:0] a,
                     logic ev, logic [31:0] ea);
    acc_valid = 1'b1; acc_pc = pc; acc_addr = a;
    @(negedge clk);
    check(req, ev, ea);
  endtask

  task automatic idle(string req);
    acc_valid = 1'b0; acc_pc = 32'hDEAD_BEEF; acc_addr = 32'h1234_5678;
    @(negedge clk);
    check(req, 1'b0, '0);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, '0);
    acc("R1 first access miss", 32'h0000_0AFC, 32'h0000_4000, 1'b0, '0);
    idle("R10 idle");
  endtask

  task automatic t_const_stride;
    acc("R2 alloc", 32'h100, 32'h1000, 1'b0, '0);
    acc("R5 init mismatch", 32'h100, 32'h1010, 1'b0, '0);
    acc("R6 third access", 32'h100, 32'h1020, 1'b1, 32'h1030);
    acc("R6 steady", 32'h100, 32'h1030, 1'b1, 32'h1040);
    acc("R4 steady hold", 32'h100, 32'h1040, 1'b1, 32'h1050);
    idle("R10 idle no pf");
    acc("R3 after idle", 32'h100, 32'h1050, 1'b1, 32'h1060);
  endtask

  task automatic t_zero_stride;
    for (int i = 0; i < 4; i++)
      acc("R7 zero stride", 32'h204, 32'h5000, 1'b0, '0);
  endtask

  task automatic t_break;
    acc("R2 alloc", 32'h308, 32'h2000, 1'b0, '0);
    acc("R5 mismatch", 32'h308, 32'h2010, 1'b0, '0);
    acc("R6 steady", 32'h308, 32'h2020, 1'b1, 32'h2030);
    acc("R5 steady break", 32'h308, 32'h2050, 1'b0, '0);
    acc("R4 init match", 32'h308, 32'h2080, 1'b1, 32'h20B0);
  endtask

  task automatic t_nopred;
    acc("R2 alloc", 32'h40C, 32'h0, 1'b0, '0);
    acc("R5 to trans", 32'h40C, 32'h1, 1'b0, '0);
    acc("R5 to nopred", 32'h40C, 32'h3, 1'b0, '0);
    acc("R5 nopred hold", 32'h40C, 32'h6, 1'b0, '0);
    acc("R4 nopred to trans", 32'h40C, 32'h9, 1'b0, '0);
    acc("R4 trans to steady", 32'h40C, 32'hC, 1'b1, 32'hF);
  endtask

  task automatic t_alias;
    acc("R8 alias alloc", 32'h200, 32'h7000, 1'b0, '0);
    acc("R8 replaced miss", 32'h100, 32'h1070, 1'b0, '0);
    acc("R8 realloc trans", 32'h100, 32'h1080, 1'b0, '0);
    acc("R8 realloc steady", 32'h100, 32'h1090, 1'b1, 32'h10A0);
  endtask

  task automatic t_interleave;
    acc("R9 A alloc", 32'h510, 32'h100, 1'b0, '0);
    acc("R9 B alloc", 32'h614, 32'h900, 1'b0, '0);
    acc("R9 A trans", 32'h510, 32'h104, 1'b0, '0);
    acc("R9 B trans", 32'h614, 32'h8F0, 1'b0, '0);
    acc("R9 A steady", 32'h510, 32'h108, 1'b1, 32'h10C);
    acc("R9 B steady neg", 32'h614, 32'h8E0, 1'b1, 32'h8D0);
    acc("R9 A steady", 32'h510, 32'h10C, 1'b1, 32'h110);
    acc("R9 B steady neg", 32'h614, 32'h8D0, 1'b1, 32'h8C0);
  endtask

  task automatic t_wrap;
    acc("R9 wrap alloc", 32'h718, 32'hFFFF_FFF0, 1'b0, '0);
    acc("R9 wrap trans", 32'h718, 32'hFFFF_FFF8, 1'b0, '0);
    acc("R9 wrap steady", 32'h718, 32'h0000_0000, 1'b1, 32'h0000_0008);
    acc("R6 wrap pf", 32'h718, 32'hFFFF_FFF8 + 32'h10, 1'b1, 32'h0000_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_const_stride();
    t_zero_stride();
    t_break();
    t_nopred();
    t_alias();
    t_interleave();
    t_wrap();
    idle("R10 final idle");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule